// File: doc/BRIEF.md
# Issue-Stage Hazard Scoreboard

This block is the control half of the issue stage in a pipeline that issues in program order, lets results reach the register file out of order and retires in order. Three execution pipes of different depth share one register-file write port: a single-stage ALU pipe, a two-stage load pipe and a five-stage multiply pipe. Each of them is followed by one write-back stage. Each cycle the block looks at one decoded instruction: its class, its destination and its two sources. It returns a combinational grant. An instruction leaves the issue stage at the clock edge where it is valid and granted. While the grant is low, the front end holds the same instruction, and every younger one waits behind it.

Each architectural register has a small pending-entry state machine. Its states are `P_IDLE` (no result in flight), `P_COUNT` (the result is not yet forwardable) and `P_FWD` (the result sits at the output of the producer's last execute stage for exactly one cycle). Its transitions are: issue of an ALU producer (`P_IDLE`/`P_FWD` to `P_FWD`); issue of a load or multiply producer (`P_IDLE`/`P_FWD` to `P_COUNT`); count expiry (`P_COUNT` to `P_FWD`); one forwarding cycle spent (`P_FWD` to `P_IDLE`); and flush (any state to `P_IDLE`). A shift vector of future write-back cycles keeps two instructions from ever reaching write-back together. The vector is also driven out so that the write-back control can see it.

Top module: `issue_scoreboard`

## Requirements
- R1: `issue_grant` is never high while `in_valid` is low. An instruction counts as issued only at a rising edge where `in_valid` and `issue_grant` are both high.
- R2: Class encoding on `in_cls` is 0 ALU, 1 load and 2 multiply. The instruction reaches write-back 2, 3 or 6 cycles after its issue cycle, in that order of class.
- R3: A source register other than R0 stalls issue while its producer is not yet forwardable. An ALU producer is forwardable from 1 cycle after its issue cycle, a load producer from 2 cycles after, and a multiply producer from 5 cycles after.
- R4: `wb_resv` bit k is 1 exactly when some issued instruction reaches write-back k cycles from now. Issue is withheld when the bit for the new instruction's write-back offset is already 1.
- R5: In the first cycle a pending source may issue, its select (`byp_sel0` for the first source, `byp_sel1` for the second) is 01 for an ALU producer, 10 for a load producer and 11 for a multiply producer. In every other cycle it is 00, which means register file.
- R6: An instruction whose destination (other than R0) has a producer that is not yet forwardable is stalled, so that writes to one register reach write-back in order.
- R7: R0 is never pending. A source of R0 never stalls and always selects 00, and writing R0 creates no dependency.
- R8: While `flush` is high the grant is low. From the next cycle, all pending entries and all write-back reservations are clear.
- R9: After reset, `wb_resv` is zero, both selects are 00, and the first valid instruction is granted.
- R10: An instruction is not held back merely because an older, longer-latency instruction is still in flight. A younger ALU operation may reach write-back before an older multiply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Clears every pending entry and reservation |
| in_valid | input | 1 | A decoded instruction is present |
| in_cls | input | 2 | Instruction class: 0 ALU, 1 load, 2 multiply |
| in_dst | input | RW | Destination register |
| in_src0 | input | RW | First source register |
| in_src1 | input | RW | Second source register |
| issue_grant | output | 1 | Instruction may leave issue this cycle |
| byp_sel0 | output | 2 | Operand select for first source |
| byp_sel1 | output | 2 | Operand select for second source |
| wb_resv | output | 7 | Write-back occupancy, bit k = k cycles ahead |

## Verification
A pending entry stuck in the counting state shows up as a grant that stays low one or more cycles past the forwarding point. The same fault also gives a wrong select code in the very cycle the consumer should have issued. A lost or misplaced reservation bit shows on `wb_resv` at once, in the next cycle after the issue. If it is not caught there, it lets two instructions be granted with the same write-back cycle within six cycles. Because the bench keeps its own record of the cycle at which each register becomes ready and which cycles are taken for write-back, any such error surfaces in the first cycle where its grant, selects or occupancy vector differ.

// File: rtl/iss_pkg.sv
package iss_pkg;

    localparam int X_STAGES = 1;
    localparam int L_STAGES = 2;
    localparam int Y_STAGES = 5;
    localparam int MAX_LAT  = Y_STAGES + 1;
    localparam int RES_W    = MAX_LAT + 1;
    localparam int LAT_W    = $clog2(RES_W);
    localparam int CNT_W    = $clog2(Y_STAGES + 1);

    typedef enum logic [1:0] {
        OP_ALU  = 2'd0,
        OP_LOAD = 2'd1,
        OP_MUL  = 2'd2,
        OP_RSVD = 2'd3
    } op_cls_e;

    typedef enum logic [1:0] {
        SRC_RF = 2'd0,
        SRC_X0 = 2'd1,
        SRC_L1 = 2'd2,
        SRC_Y4 = 2'd3
    } byp_sel_e;

    typedef enum logic [1:0] {
        P_IDLE  = 2'd0,
        P_COUNT = 2'd1,
        P_FWD   = 2'd2
    } pend_state_e;

    function automatic int fwd_lat(op_cls_e c);
        unique case (c)
            OP_LOAD: return L_STAGES;
            OP_MUL:  return Y_STAGES;
            default: return X_STAGES;
        endcase
    endfunction

    function automatic int wb_lat(op_cls_e c);
        return fwd_lat(c) + 1;
    endfunction

    function automatic byp_sel_e unit_code(op_cls_e c);
        unique case (c)
            OP_LOAD: return SRC_L1;
            OP_MUL:  return SRC_Y4;
            default: return SRC_X0;
        endcase
    endfunction

endpackage

// File: rtl/pend_entry.sv
module pend_entry
    import iss_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             set_en,
    input  logic [1:0]       set_unit,
    input  logic [CNT_W-1:0] set_cnt,
    output logic             is_wait,
    output logic             is_fwd,
    output logic [1:0]       unit
);

    pend_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [1:0]       unit_q, unit_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= P_IDLE;
            cnt_q   <= '0;
            unit_q  <= SRC_RF;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            unit_q  <= unit_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unit_d  = unit_q;
        if (flush) begin
            state_d = P_IDLE;
            cnt_d   = '0;
        end else if (set_en) begin
            unit_d  = set_unit;
            cnt_d   = set_cnt;
            state_d = (set_cnt == '0) ? P_FWD : P_COUNT;
        end else begin
            unique case (state_q)
                P_IDLE: ;
                P_COUNT: begin
                    if (cnt_q == CNT_W'(1)) begin
                        state_d = P_FWD;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q - CNT_W'(1);
                    end
                end
                P_FWD:   state_d = P_IDLE;
                default: state_d = P_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        is_wait = 1'b0;
        is_fwd  = 1'b0;
        unit    = SRC_RF;
        unique case (state_q)
            P_IDLE: ;
            P_COUNT: is_wait = 1'b1;
            P_FWD: begin
                is_fwd = 1'b1;
                unit   = unit_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/wb_reserve.sv
module wb_reserve
    import iss_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             take,
    input  logic [LAT_W-1:0] lat,
    output logic             slot_busy,
    output logic [RES_W-1:0] resv
);

    logic [RES_W-1:0] resv_q;
    logic [RES_W-1:0] claim;

    assign claim     = take ? (RES_W'(1) << lat) : '0;
    assign slot_busy = resv_q[lat];
    assign resv      = resv_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            resv_q <= '0;
        else if (flush)
            resv_q <= '0;
        else
            resv_q <= (resv_q | claim) >> 1;
    end

endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
    import iss_pkg::*;
#(
    parameter  int NREG = 32,
    localparam int RW   = $clog2(NREG)
) (
    input  logic [NREG-1:0]      ent_wait,
    input  logic [NREG-1:0]      ent_fwd,
    input  logic [NREG-1:0][1:0] ent_unit,
    input  logic [RW-1:0]        src0,
    input  logic [RW-1:0]        src1,
    input  logic [RW-1:0]        dst,
    output logic                 src_stall,
    output logic                 waw_stall,
    output logic [1:0]           sel0,
    output logic [1:0]           sel1
);

    logic [1:0][RW-1:0] srcs;
    logic [1:0][1:0]    sels;
    logic [1:0]         stalls;

    assign srcs = {src1, src0};

    for (genvar s = 0; s < 2; s++) begin : g_src
        always_comb begin
            stalls[s] = 1'b0;
            sels[s]   = SRC_RF;
            if (srcs[s] != '0) begin
                stalls[s] = ent_wait[srcs[s]];
                if (ent_fwd[srcs[s]])
                    sels[s] = ent_unit[srcs[s]];
            end
        end
    end

    assign src_stall = |stalls;
    assign sel0      = sels[0];
    assign sel1      = sels[1];
    assign waw_stall = (dst != '0) && ent_wait[dst];

endmodule

// File: rtl/issue_scoreboard.sv
module issue_scoreboard
    import iss_pkg::*;
#(
    parameter  int NREG = 32,
    localparam int RW   = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             in_valid,
    input  logic [1:0]       in_cls,
    input  logic [RW-1:0]    in_dst,
    input  logic [RW-1:0]    in_src0,
    input  logic [RW-1:0]    in_src1,
    output logic             issue_grant,
    output logic [1:0]       byp_sel0,
    output logic [1:0]       byp_sel1,
    output logic [RES_W-1:0] wb_resv
);

    op_cls_e              cls;
    logic [LAT_W-1:0]     lat;
    logic [CNT_W-1:0]     cnt_init;
    logic [1:0]           unit_new;
    logic [NREG-1:0]      ent_wait, ent_fwd;
    logic [NREG-1:0][1:0] ent_unit;
    logic                 src_stall, waw_stall, slot_busy;

    assign cls      = op_cls_e'(in_cls);
    assign lat      = LAT_W'(wb_lat(cls));
    assign cnt_init = CNT_W'(fwd_lat(cls) - 1);
    assign unit_new = unit_code(cls);

    for (genvar g = 0; g < NREG; g++) begin : g_ent
        if (g == 0) begin : g_zero
            assign ent_wait[g] = 1'b0;
            assign ent_fwd[g]  = 1'b0;
            assign ent_unit[g] = SRC_RF;
        end else begin : g_reg
            pend_entry u_ent (
                .clk      (clk),
                .rst_n    (rst_n),
                .flush    (flush),
                .set_en   (issue_grant && (in_dst == RW'(g))),
                .set_unit (unit_new),
                .set_cnt  (cnt_init),
                .is_wait  (ent_wait[g]),
                .is_fwd   (ent_fwd[g]),
                .unit     (ent_unit[g])
            );
        end
    end

    hazard_unit #(.NREG(NREG)) u_haz (
        .ent_wait  (ent_wait),
        .ent_fwd   (ent_fwd),
        .ent_unit  (ent_unit),
        .src0      (in_src0),
        .src1      (in_src1),
        .dst       (in_dst),
        .src_stall (src_stall),
        .waw_stall (waw_stall),
        .sel0      (byp_sel0),
        .sel1      (byp_sel1)
    );

    wb_reserve u_wb (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .take      (issue_grant),
        .lat       (lat),
        .slot_busy (slot_busy),
        .resv      (wb_resv)
    );

    assign issue_grant = in_valid && !flush && !src_stall && !waw_stall && !slot_busy;

endmodule

// File: rtl/issue_scoreboard_chk.sv
module issue_scoreboard_chk
    import iss_pkg::*;
#(
    parameter  int NREG = 32,
    localparam int RW   = $clog2(NREG)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             in_valid,
    input logic [1:0]       in_cls,
    input logic [RW-1:0]    in_src0,
    input logic [RW-1:0]    in_src1,
    input logic             issue_grant,
    input logic [1:0]       byp_sel0,
    input logic [1:0]       byp_sel1,
    input logic [RES_W-1:0] wb_resv,
    input logic [NREG-1:0]  ent_wait
);

    int unsigned lat_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lat_q <= 1;
        else        lat_q <= unsigned'(wb_lat(op_cls_e'(in_cls)));
    end

    a_r1_no_grant_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> !issue_grant);

    a_r3_src0_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_grant && in_src0 != '0) |-> !ent_wait[in_src0]);

    a_r3_src1_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_grant && in_src1 != '0) |-> !ent_wait[in_src1]);

    a_r4_slot_recorded: assert property (@(posedge clk) disable iff (!rst_n)
        issue_grant |=> wb_resv[lat_q - 1]);

    a_r7_r0_select: assert property (@(posedge clk) disable iff (!rst_n)
        ((in_src0 == '0) |-> (byp_sel0 == SRC_RF)) and ((in_src1 == '0) |-> (byp_sel1 == SRC_RF)));

    a_r8_flush_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !issue_grant);

    a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (wb_resv == '0) && (ent_wait == '0));

endmodule

bind issue_scoreboard issue_scoreboard_chk #(.NREG(NREG)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .in_valid    (in_valid),
    .in_cls      (in_cls),
    .in_src0     (in_src0),
    .in_src1     (in_src1),
    .issue_grant (issue_grant),
    .byp_sel0    (byp_sel0),
    .byp_sel1    (byp_sel1),
    .wb_resv     (wb_resv),
    .ent_wait    (ent_wait)
);

// File: tb/issue_scoreboard_bench.sv
module issue_scoreboard_bench;

    localparam int NREG = 32;
    localparam int RW   = 5;
    localparam int RESW = 7;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            flush = 1'b0;
    logic            in_valid = 1'b0;
    logic [1:0]      in_cls = 2'd0;
    logic [RW-1:0]   in_dst = '0, in_src0 = '0, in_src1 = '0;
    logic            issue_grant;
    logic [1:0]      byp_sel0, byp_sel1;
    logic [RESW-1:0] wb_resv;

    issue_scoreboard #(.NREG(NREG)) u_issue_scoreboard (
        .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
        .in_cls(in_cls), .in_dst(in_dst), .in_src0(in_src0), .in_src1(in_src1),
        .issue_grant(issue_grant), .byp_sel0(byp_sel0), .byp_sel1(byp_sel1),
        .wb_resv(wb_resv)
    );

    always #5 clk = ~clk;

    int n_chk = 0, n_bad = 0, cyc = 0;
    int rdy  [NREG];
    int unt  [NREG];
    int wbt  [64];
    bit done = 1'b0;

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    function automatic int m_wb(int c);  return c == 0 ? 2 : (c == 1 ? 3 : 6); endfunction
    function automatic int m_fw(int c);  return c == 0 ? 1 : (c == 1 ? 2 : 5); endfunction
    function automatic int m_sel(int s); return (s != 0 && cyc == rdy[s]) ? unt[s] : 0; endfunction
    function automatic bit m_pend(int r); return r != 0 && cyc < rdy[r]; endfunction
    function automatic bit m_wbbusy(int t); return wbt[t % 64] == t; endfunction

    task automatic m_clear();
        foreach (rdy[i]) begin rdy[i] = -100; unt[i] = 0; end
        foreach (wbt[i]) wbt[i] = -1;
    endtask

    // one cycle: drive, compare, update model; returns grant
    task automatic step(input bit v, input bit fl, input int c, input int d,
                        input int s0, input int s1, output bit g);
        bit eg;
        int er;
        @(negedge clk);
        in_valid = v; flush = fl; in_cls = 2'(c);
        in_dst = RW'(d); in_src0 = RW'(s0); in_src1 = RW'(s1);
        #1;
        eg = v && !fl && !m_pend(s0) && !m_pend(s1) && !m_pend(d) && !m_wbbusy(cyc + m_wb(c));
        chk(issue_grant == eg, "R1 R3 R4 R6 grant", int'(issue_grant), int'(eg));
        chk(byp_sel0 == 2'(m_sel(s0)), "R5 sel0", int'(byp_sel0), m_sel(s0));
        chk(byp_sel1 == 2'(m_sel(s1)), "R5 sel1", int'(byp_sel1), m_sel(s1));
        er = 0;
        for (int k = 0; k < RESW; k++) if (m_wbbusy(cyc + k)) er |= (1 << k);
        chk(int'(wb_resv) == er, "R2 R4 wb_resv", int'(wb_resv), er);
        g = issue_grant;
        if (fl) m_clear();
        else if (eg) begin
            wbt[(cyc + m_wb(c)) % 64] = cyc + m_wb(c);
            if (d != 0) begin rdy[d] = cyc + m_fw(c); unt[d] = c + 1; end
        end
    endtask

    task automatic issue(input int c, input int d, input int s0, input int s1);
        bit g = 1'b0;
        for (int t = 0; t < 40 && !g; t++) step(1'b1, 1'b0, c, d, s0, s1, g);
    endtask

    task automatic idle(input int n);
        bit g;
        for (int t = 0; t < n; t++) step(1'b0, 1'b0, 0, 0, 0, 0, g);
    endtask

    initial begin
        bit g;
        int c, d, s0, s1;
        void'($urandom(32'd1234));
        m_clear();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R9: reset state
        #1;
        chk(wb_resv == '0, "R9 resv", int'(wb_resv), 0);
        chk(byp_sel0 == 2'd0 && byp_sel1 == 2'd0, "R9 sels", int'(byp_sel0), 0);
        step(1'b1, 1'b0, 2, 6, 7, 8, g);
        chk(g, "R9 first grant", int'(g), 1);
        // R10: younger ADD granted right after older MUL
        step(1'b1, 1'b0, 0, 9, 10, 11, g);
        chk(g, "R10 ooo writeback", int'(g), 1);
        // rest of the directed mix
        issue(0, 11, 12, 13);
        issue(0, 13, 14, 15);
        issue(0, 19, 13, 10);
        issue(1, 2, 3, 0);
        issue(0, 12, 16, 19);
        issue(1, 5, 2, 0);
        issue(0, 15, 20, 21);
        idle(8);
        // R3/R5 load-use: consumer waits two cycles, then selects load output
        issue(1, 4, 0, 0);
        step(1'b1, 1'b0, 0, 7, 4, 0, g);
        chk(!g, "R3 load use stall", int'(g), 0);
        step(1'b1, 1'b0, 0, 7, 0, 4, g);
        chk(g && byp_sel1 == 2'd2, "R5 load fwd", int'(byp_sel1), 2);
        idle(8);
        // R7: R0 destination never pending
        issue(2, 0, 0, 0);
        step(1'b1, 1'b0, 0, 3, 0, 0, g);
        chk(g && byp_sel0 == 2'd0, "R7 r0 no dep", int'(g), 1);
        idle(8);
        // R6: WAW stall behind a multiply
        issue(2, 8, 0, 0);
        step(1'b1, 1'b0, 0, 8, 0, 0, g);
        chk(!g, "R6 waw stall", int'(g), 0);
        // R8: flush clears everything
        step(1'b1, 1'b1, 0, 9, 8, 0, g);
        chk(!g, "R8 flush grant", int'(g), 0);
        step(1'b1, 1'b0, 0, 9, 8, 8, g);
        chk(g && wb_resv == '0, "R8 after flush", int'(wb_resv), 0);
        // constrained random
        for (int n = 0; n < 600; n++) begin
            c  = int'($urandom % 3);
            d  = int'($urandom % 8);
            s0 = int'($urandom % 8);
            s1 = int'($urandom % 8);
            if ($urandom % 40 == 0) step(1'b1, 1'b1, c, d, s0, s1, g);
            else if ($urandom % 8 == 0) idle(1);
            else issue(c, d, s0, s1);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule